// File: doc/BRIEF.md
# PSK ID tag modulator

This block is the digital core of a read-only identification tag that answers with phase-shift keying. It runs on a clock taken from the reader's carrier. From a 40-bit identifier it assembles a 64-bit frame: a run of ones as a header, ten rows of four identifier bits each followed by a row parity bit, four column parity bits and a closing zero. It sends this frame bit by bit and starts again at the first bit as soon as the last one is out. It does this for as long as it is clocked and enabled.

The modulation output flips on every carrier cycle. This produces a subcarrier at half the carrier rate. Each frame bit lasts sixteen carrier cycles. When the bit that is about to start is a 0, the output skips one flip at the start of that bit. This reverses the phase of the subcarrier, and the reader decodes the reversal as a 0. A bit that starts without a reversal reads as a 1.

Rows 0 and 1 carry odd parity. Rows 2 to 9 carry even parity. The column parity is even and covers all ten rows. Two strobes let neighbouring logic line up with the serial stream: one marks the first cycle of every bit, and one marks the first cycle of the frame.

Top module: `psk_tag_modulator`

## Requirements
- R1: While reset is asserted, and right after it, `modOut` is 0, the sequencer stands at frame bit 0 in its first carrier cycle, and both `bitStrobe` and `frameStrobe` are 1.
- R2: On every enabled clock edge that does not start a new bit, `modOut` inverts.
- R3: Each frame bit lasts exactly 16 enabled carrier cycles. `bitStrobe` is high only in the first cycle of a bit. `frameStrobe` is high only in the first cycle of frame bit 0.
- R4: On the enabled edge that starts a new bit, `modOut` inverts when that bit is 1. When that bit is 0, `modOut` keeps its value for one extra cycle, which reverses the phase.
- R5: Frame bits 0 to 8 are 1 and bit 63 is 0. Row r (r = 0 to 9) occupies bits 9+5r to 13+5r. Its first four bits are idCode[39-4r] down to idCode[36-4r], and its fifth bit is the row parity.
- R6: For rows 0 and 1, the row parity bit makes the count of ones in the five row bits odd.
- R7: For rows 2 to 9, the row parity bit makes the count of ones in the five row bits even.
- R8: Frame bit 59+c (c = 0 to 3) is the even parity of column c over all ten rows. Column c is the bit in position c of each row's four identifier bits.
- R9: After frame bit 63, transmission continues with frame bit 0 without any gap.
- R10: On a clock edge with `enable` low, the bit position, the cycle within the bit, `modOut` and both strobes all stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the carrier rate |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Advances the sequencer and modulator on each edge where it is high |
| idCode | input | 40 | Identifier placed into the frame rows, bit 39 sent first |
| modOut | output | 1 | Modulation switch control |
| bitStrobe | output | 1 | High in the first carrier cycle of each bit |
| frameStrobe | output | 1 | High in the first carrier cycle of frame bit 0 |

## Verification
The hardest case to reach is a bit boundary that coincides with a 0 bit while `enable` has been dropping at irregular intervals. The missed flip must land on the boundary edge itself and not on a stalled cycle. The stimulus runs a whole frame with `enable` low on every third cycle, using an identifier whose rows mix odd and even weights, so that reversals fall on boundaries reached after stalls. Further runs use an all-zero identifier and an all-ones identifier, which give the row-parity extremes, and then one more identifier after a reset asserted mid-frame. Each run crosses the frame wrap at least once.

// File: rtl/psk_tag_pkg.sv
package psk_tag_pkg;

  // Strobes from the sequencer to the modulation datapath
  typedef struct packed {
    logic step;      // an enabled carrier edge
    logic boundary;  // this enabled edge starts the next bit
  } seqStrobeT;

endpackage

// File: rtl/psk_tag_frame.sv
module psk_tag_frame #(
  parameter int ROWS = 10,
  parameter int NIBBLE = 4,
  parameter int HDR_LEN = 9,
  parameter int ODD_ROWS = 2,
  localparam int ID_BITS = ROWS * NIBBLE,
  localparam int FRAME_LEN = HDR_LEN + ROWS * (NIBBLE + 1) + NIBBLE + 1
) (
  input  logic [ID_BITS-1:0]   idCode,
  output logic [FRAME_LEN-1:0] frame
);

  localparam int ROW_LEN = NIBBLE + 1;
  localparam int COL_BASE = HDR_LEN + ROWS * ROW_LEN;

  assign frame[HDR_LEN-1:0] = '1;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [NIBBLE-1:0] nib;
    assign nib = idCode[ID_BITS-1-r*NIBBLE -: NIBBLE];
    for (genvar c = 0; c < NIBBLE; c++) begin : g_bit
      assign frame[HDR_LEN + r*ROW_LEN + c] = nib[NIBBLE-1-c];
    end
    if (r < ODD_ROWS) begin : g_odd
      assign frame[HDR_LEN + r*ROW_LEN + NIBBLE] = ~^nib;
    end else begin : g_even
      assign frame[HDR_LEN + r*ROW_LEN + NIBBLE] = ^nib;
    end
  end

  for (genvar c = 0; c < NIBBLE; c++) begin : g_col
    logic [ROWS-1:0] colBits;
    for (genvar r = 0; r < ROWS; r++) begin : g_cell
      assign colBits[r] = idCode[ID_BITS-1-r*NIBBLE-c];
    end
    assign frame[COL_BASE + c] = ^colBits;
  end

  assign frame[FRAME_LEN-1] = 1'b0;

endmodule

// File: rtl/psk_tag_seq.sv
module psk_tag_seq
  import psk_tag_pkg::*;
#(
  parameter int BIT_PERIOD = 16,
  parameter int FRAME_LEN = 64,
  localparam int PW = $clog2(BIT_PERIOD),
  localparam int IW = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  output seqStrobeT     ctl,
  output logic [IW-1:0] nextIdx,
  output logic          bitStrobe,
  output logic          frameStrobe
);

  logic [PW-1:0] phaseCnt;
  logic [IW-1:0] bitIdx;
  logic          lastPhase;
  logic          lastBit;

  assign lastPhase = (phaseCnt == PW'(BIT_PERIOD - 1));
  assign lastBit   = (bitIdx == IW'(FRAME_LEN - 1));
  assign nextIdx   = lastBit ? '0 : bitIdx + IW'(1);

  assign ctl.step     = enable;
  assign ctl.boundary = enable && lastPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      bitIdx   <= '0;
    end else if (enable) begin
      if (lastPhase) begin
        phaseCnt <= '0;
        bitIdx   <= nextIdx;
      end else begin
        phaseCnt <= phaseCnt + PW'(1);
      end
    end
  end

  assign bitStrobe   = (phaseCnt == '0);
  assign frameStrobe = bitStrobe && (bitIdx == '0);

endmodule

// File: rtl/psk_tag_mod.sv
module psk_tag_mod
  import psk_tag_pkg::*;
#(
  parameter int FRAME_LEN = 64,
  localparam int IW = $clog2(FRAME_LEN)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobeT            ctl,
  input  logic [FRAME_LEN-1:0] frame,
  input  logic [IW-1:0]        nextIdx,
  output logic                 modOut
);

  logic upcomingBit;
  logic holdPhase;

  assign upcomingBit = frame[nextIdx];
  // a zero bit skips one flip at its start: the subcarrier phase reverses
  assign holdPhase = ctl.boundary && !upcomingBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modOut <= 1'b0;
    end else if (ctl.step && !holdPhase) begin
      modOut <= ~modOut;
    end
  end

endmodule

// File: rtl/psk_tag_modulator.sv
module psk_tag_modulator
  import psk_tag_pkg::*;
#(
  parameter int ROWS = 10,
  parameter int NIBBLE = 4,
  parameter int HDR_LEN = 9,
  parameter int ODD_ROWS = 2,
  parameter int BIT_PERIOD = 16,
  localparam int ID_BITS = ROWS * NIBBLE,
  localparam int FRAME_LEN = HDR_LEN + ROWS * (NIBBLE + 1) + NIBBLE + 1,
  localparam int IW = $clog2(FRAME_LEN)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [ID_BITS-1:0] idCode,
  output logic               modOut,
  output logic               bitStrobe,
  output logic               frameStrobe
);

  logic [FRAME_LEN-1:0] frame;
  logic [IW-1:0]        nextIdx;
  seqStrobeT            ctl;

  psk_tag_frame #(
    .ROWS(ROWS), .NIBBLE(NIBBLE), .HDR_LEN(HDR_LEN), .ODD_ROWS(ODD_ROWS)
  ) u_frame (
    .idCode(idCode),
    .frame (frame)
  );

  psk_tag_seq #(
    .BIT_PERIOD(BIT_PERIOD), .FRAME_LEN(FRAME_LEN)
  ) u_seq (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .ctl        (ctl),
    .nextIdx    (nextIdx),
    .bitStrobe  (bitStrobe),
    .frameStrobe(frameStrobe)
  );

  psk_tag_mod #(
    .FRAME_LEN(FRAME_LEN)
  ) u_mod (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .frame  (frame),
    .nextIdx(nextIdx),
    .modOut (modOut)
  );

endmodule

// File: rtl/psk_tag_modulator_chk.sv
module psk_tag_modulator_chk #(
  parameter int BIT_PERIOD = 16,
  parameter int FRAME_LEN = 64,
  localparam int PW = $clog2(BIT_PERIOD),
  localparam int IW = $clog2(FRAME_LEN)
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic modOut,
  input logic bitStrobe,
  input logic frameStrobe
);

  // independent counters of enabled cycles within a bit and bits within a frame
  logic [PW-1:0] cycCnt;
  logic [IW-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt <= '0;
      bitCnt <= '0;
    end else if (enable) begin
      if (cycCnt == PW'(BIT_PERIOD - 1)) begin
        cycCnt <= '0;
        bitCnt <= (bitCnt == IW'(FRAME_LEN - 1)) ? '0 : bitCnt + IW'(1);
      end else begin
        cycCnt <= cycCnt + PW'(1);
      end
    end
  end

  a_r3_bit_spacing: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe == (cycCnt == '0));

  a_r9_frame_spacing: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe == (cycCnt == '0 && bitCnt == '0));

  a_r3_frame_on_bit: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |-> bitStrobe);

  a_r2_inner_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cycCnt != PW'(BIT_PERIOD - 1)) |=> (modOut != $past(modOut)));

  a_r10_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> ($stable(modOut) && $stable(bitStrobe) && $stable(frameStrobe)));

endmodule

bind psk_tag_modulator psk_tag_modulator_chk #(
  .BIT_PERIOD(BIT_PERIOD), .FRAME_LEN(FRAME_LEN)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .modOut     (modOut),
  .bitStrobe  (bitStrobe),
  .frameStrobe(frameStrobe)
);

// File: tb/psk_tag_modulator_tb.sv
module psk_tag_modulator_tb;

  localparam int PERIOD = 16;
  localparam int FLEN = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [39:0] idCode = '0;
  logic        modOut;
  logic        bitStrobe;
  logic        frameStrobe;

  always #4 clk = ~clk;

  psk_tag_modulator u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .idCode(idCode),
    .modOut(modOut), .bitStrobe(bitStrobe), .frameStrobe(frameStrobe)
  );

  typedef struct {
    logic  mod;
    logic  bs;
    logic  fs;
    string tag;
  } expT;

  expT q[$];
  int  checks = 0;
  int  fails = 0;
  int  mBit = 0;
  int  mPh = 0;
  logic mMod = 1'b0;

  // Frame built from R5..R8
  function automatic logic [63:0] refFrame(input logic [39:0] id);
    logic [63:0] f;
    logic [3:0]  col;
    f = '0;
    col = '0;
    for (int h = 0; h < 9; h++) f[h] = 1'b1;
    for (int r = 0; r < 10; r++) begin
      int ones;
      ones = 0;
      for (int c = 0; c < 4; c++) begin
        logic b;
        b = id[39 - 4*r - c];
        f[9 + 5*r + c] = b;
        ones += int'(b);
        col[c] = col[c] ^ b;
      end
      if (r < 2) f[9 + 5*r + 4] = (ones % 2 == 0);  // R6 odd
      else       f[9 + 5*r + 4] = (ones % 2 == 1);  // R7 even
    end
    for (int c = 0; c < 4; c++) f[59 + c] = col[c];  // R8
    f[63] = 1'b0;
    return f;
  endfunction

  function automatic string tagFor(input int b);
    if (b == 0) return "R9 wrap";
    if (b < 9) return "R5 header";
    if (b < 59) begin
      if ((b - 9) % 5 == 4) return ((b - 9) / 5 < 2) ? "R6 odd row parity" : "R7 even row parity";
      return "R5 id bit";
    end
    if (b < 63) return "R8 column parity";
    return "R5 stop";
  endfunction

  // Driver: sets inputs at a falling edge and pushes the state expected after the next rising edge
  task automatic step(input logic en, input logic [39:0] id);
    logic [63:0] f;
    string tag;
    enable = en;
    idCode = id;
    f = refFrame(id);
    if (!en) begin
      tag = "R10 disabled";
    end else if (mPh == PERIOD - 1) begin
      mPh = 0;
      mBit = (mBit == FLEN - 1) ? 0 : mBit + 1;
      if (f[mBit]) mMod = ~mMod;
      tag = {"R4/R3 boundary ", tagFor(mBit)};
    end else begin
      mPh++;
      mMod = ~mMod;
      tag = "R2 in-bit toggle";
    end
    q.push_back('{mMod, (mPh == 0), (mPh == 0 && mBit == 0), tag});
    @(negedge clk);
  endtask

  task automatic runCycles(input int n, input logic [39:0] id, input bit gaps);
    for (int i = 0; i < n; i++) step(gaps ? (i % 3 != 1) : 1'b1, id);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic checkOne(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic checkReset();
    checkOne("R1 modOut low", modOut, 1'b0);
    checkOne("R1 bitStrobe at bit start", bitStrobe, 1'b1);
    checkOne("R1 frameStrobe at bit 0", frameStrobe, 1'b1);
    mBit = 0;
    mPh = 0;
    mMod = 1'b0;
  endtask

  // Monitor: compares outputs midway between rising and falling edges
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        expT e;
        e = q.pop_front();
        checks++;
        if (modOut !== e.mod || bitStrobe !== e.bs || frameStrobe !== e.fs) begin
          fails++;
          $display("FAIL %s: actual mod/bs/fs=%b%b%b expected=%b%b%b",
                   e.tag, modOut, bitStrobe, frameStrobe, e.mod, e.bs, e.fs);
        end
      end
    end
  end

  initial begin
    #(100000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    // all-zero id: rows 0,1 get parity 1, later rows 0; two wraps
    runCycles(2 * FLEN * PERIOD + 100, 40'h00_0000_0000, 1'b0);
    // all-ones id: the same parity pattern from four-one rows, column parity 0
    runCycles(FLEN * PERIOD + 80, 40'hFF_FFFF_FFFF, 1'b0);
    // mixed id with enable dropped every third cycle
    runCycles(FLEN * PERIOD * 3 / 2 + 200, 40'h3A_C596_E10F, 1'b1);
    drain();
    // reset mid-frame returns to the start state
    rstN = 1'b0;
    @(negedge clk);
    checkReset();
    rstN = 1'b1;
    runCycles(FLEN * PERIOD + 120, 40'h84_210C_3E57, 1'b0);
    drain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule